// File: doc/BRIEF.md
# Radix-4 Digit-Serial MSDF Multiplier

This block multiplies two fractional operands delivered one radix-4 signed digit per cycle, most significant digit first, and returns their product as a stream of signed digits, also most significant first. An operand of NDIG digits x_1..x_NDIG has the value sum x_i * 4^-i. Because the product leaves the block digit by digit, a downstream stage that only needs the sign of a result can act on the first non-zero digit and ignore the rest, with no conversion back to binary.

Internally the block keeps a growing prefix of each operand, built by placing each new digit one position below the previous one. It also keeps a three-times copy of each prefix, so that every digit-by-prefix multiple needs only a shift, a negation or the stored copy. Each step folds the scaled previous residual, held in carry-save form, and the two new digit-by-prefix terms into a residual estimate through a 4-to-2 compressor. It picks an output digit by rounding the estimate to the nearest integer and removes that digit through a 3-to-2 stage. The output stream carries one more digit than each operand. Its first digit has weight 1, so the product equals sum p_i * 4^(1-i).

Top module: `msdf_mul_r4`

## Requirements
- R1: While reset is low, and in the cycle after it, pValid and pLast are 0, and no output digit appears until a start pulse is given.
- R2: A start pulse clears both operand prefixes and the residual and begins a new operation. A product computed after an abandoned partial operation is as accurate as one computed from reset.
- R3: Every digit, in and out, is a 3-bit two's-complement value in -3..+3, and the pattern 3'b100 never appears on pDigit while pValid is high.
- R4: An operand digit pair accepted at a clock edge (digValid high during an operation) yields an output digit that is valid in the cycle right after that edge.
- R5: After the NDIG-th pair is accepted, the block runs one extra step on its own, treating both operand digits as zero and ignoring the digit inputs. It outputs digit NDIG+1 one cycle after digit NDIG, with pLast high, and pValid is low in the following cycle.
- R6: The value sum p_i * 4^(1-i) over the NDIG+1 output digits differs from the exact product by at most half of 4^-NDIG. A product that is exactly representable in that many digits is produced exactly.
- R7: digValid low during an operation stalls it. No output digit appears in the stalled cycles, and the result is the same as without the stall.
- R8: digValid and digit inputs given while no operation is active produce no output digit.
- R9: A start pulse during an operation makes pValid low in the next cycle, and no further digit of the abandoned operation appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the state and begins a new operation |
| digValid | input | 1 | Operand digit pair is present this cycle |
| aDigit | input | 3 | Next digit of operand A, two's complement, -3..+3 |
| bDigit | input | 3 | Next digit of operand B, two's complement, -3..+3 |
| pDigit | output | 3 | Product digit, two's complement, -3..+3 |
| pValid | output | 1 | pDigit holds a new product digit |
| pLast | output | 1 | pDigit is the final digit of the product |

## Verification
Each product digit is due exactly one cycle after the edge that accepts its operand pair. The final digit is due one cycle after the NDIG-th digit, and pValid must fall one cycle after that. The bench changes inputs on the falling edge and samples the outputs on the next falling edge, which is the first point after the single output register has taken the new value. It expects pValid low on exactly those samples that follow a stall, a start pulse or the end of an operation. Accuracy is judged only after all NDIG+1 digits are collected, by rebuilding the product from the stream and comparing it with the exact integer product of the operand prefixes.

// File: rtl/msdf_mul_pkg.sv
package msdf_mul_pkg;

  // Strobes from the sequencer to the arithmetic datapath
  typedef struct packed {
    logic clear;   // wipe prefixes, residual and output flags
    logic step;    // perform one recurrence step this cycle
    logic flush;   // trailing step: operand digits forced to zero
    logic last;    // the digit produced by this step is the final one
  } stepCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } seqState_t;

endpackage

// File: rtl/msdf_mul_csa.sv
module msdf_mul_csa #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);

  logic [W-2:0] majority;

  always_comb begin
    sum      = x ^ y ^ z;
    majority = (x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0]) | (y[W-2:0] & z[W-2:0]);
    carry    = {majority, 1'b0};
  end

endmodule

// File: rtl/msdf_mul_ctrl.sv
module msdf_mul_ctrl
  import msdf_mul_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     digValid,
  output stepCtl_t ctl
);

  localparam int CW = $clog2(NDIG + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(NDIG - 1);

  seqState_t     state;
  logic [CW-1:0] digCount;

  always_comb begin
    ctl.clear = start;
    ctl.flush = !start && (state == ST_FLUSH);
    ctl.step  = !start && ((state == ST_RUN && digValid) || state == ST_FLUSH);
    ctl.last  = ctl.flush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      digCount <= '0;
    end else if (start) begin
      state    <= ST_RUN;
      digCount <= '0;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (digValid) begin
            if (digCount == LAST_IDX) begin
              state    <= ST_FLUSH;
              digCount <= '0;
            end else begin
              digCount <= digCount + 1'b1;
            end
          end
        end
        ST_FLUSH: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R5: the trailing step happens once, then the sequencer rests
  assert_flush_once_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FLUSH && !start) |=> (state == ST_IDLE));

  // R5: the accepted-digit count never passes the operand length
  assert_count_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (int'(digCount) < NDIG));

  // R8: nothing is stepped while no operation is active
  assert_idle_no_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !start) |-> !ctl.step);

  // R2: a start pulse always lands in a fresh run with zero digits taken
  assert_start_restarts_R2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (state == ST_RUN && digCount == '0));

endmodule

// File: rtl/msdf_mul_datapath.sv
module msdf_mul_datapath
  import msdf_mul_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  stepCtl_t   ctl,
  input  logic [2:0] aDigit,
  input  logic [2:0] bDigit,
  output logic [2:0] pDigit,
  output logic       pValid,
  output logic       pLast
);

  // Prefixes are integers in units of 4^-NDIG; the residual is in units of 4^-(NDIG+1)
  localparam int FB = 2 * NDIG + 2;   // fraction bits of the residual
  localparam int RW = 2 * NDIG + 6;   // residual and prefix width, signed
  localparam logic signed [RW-1:0] ONE_W  = {{(RW-1){1'b0}}, 1'b1};
  localparam logic signed [RW-1:0] W_INIT = ONE_W <<< (2 * (NDIG - 1));
  localparam logic signed [RW-1:0] HALF   = ONE_W <<< (FB - 1);

  // Digit times value using shifts, negation and the stored triple only
  function automatic logic signed [RW-1:0] digitMul(
    input logic [2:0]           d,
    input logic signed [RW-1:0] x1,
    input logic signed [RW-1:0] x3
  );
    case (d)
      3'b001:  digitMul = x1;
      3'b010:  digitMul = x1 <<< 1;
      3'b011:  digitMul = x3;
      3'b111:  digitMul = -x1;
      3'b110:  digitMul = -(x1 <<< 1);
      3'b101:  digitMul = -x3;
      default: digitMul = '0;
    endcase
  endfunction

  logic signed [RW-1:0] weight;
  logic signed [RW-1:0] aPre, aPre3, bPre, bPre3;
  logic signed [RW-1:0] zSum, zCar;

  logic [2:0]           aD, bD;
  logic signed [RW-1:0] w3, w9;
  logic signed [RW-1:0] aNew, aNew3, bNew, bNew3;
  logic signed [RW-1:0] termA, termB;
  logic signed [RW-1:0] zSumX4, zCarX4;
  logic signed [RW-1:0] wFull, rounded, pFull, negP;
  logic [2:0]           pSel;

  logic [RW-1:0] s1, c1, wSum, wCar, zSumNext, zCarNext;

  always_comb begin
    aD = ctl.flush ? 3'b000 : aDigit;
    bD = ctl.flush ? 3'b000 : bDigit;

    w3 = weight + (weight <<< 1);
    w9 = (weight <<< 3) + weight;

    aNew  = aPre  + digitMul(aD, weight, w3);
    aNew3 = aPre3 + digitMul(aD, w3, w9);
    bNew  = bPre  + digitMul(bD, weight, w3);
    bNew3 = bPre3 + digitMul(bD, w3, w9);

    // a_j times the previous B prefix, b_j times the updated A prefix
    termA = digitMul(aD, bPre, bPre3);
    termB = digitMul(bD, aNew, aNew3);

    zSumX4 = zSum <<< 2;
    zCarX4 = zCar <<< 2;
  end

  // 4-to-2 compressor built from two 3-to-2 rows
  msdf_mul_csa #(.W(RW)) u_row0 (
    .x(zSumX4), .y(zCarX4), .z(termA), .sum(s1), .carry(c1)
  );
  msdf_mul_csa #(.W(RW)) u_row1 (
    .x(s1), .y(c1), .z(termB), .sum(wSum), .carry(wCar)
  );

  // Round to nearest, halves upward
  always_comb begin
    wFull   = $signed(wSum) + $signed(wCar);
    rounded = wFull + HALF;
    pFull   = rounded >>> FB;
    pSel    = pFull[2:0];
    negP    = -(pFull <<< FB);
  end

  // Remove the chosen digit and keep the residual in carry-save form
  msdf_mul_csa #(.W(RW)) u_row2 (
    .x(wSum), .y(wCar), .z(negP), .sum(zSumNext), .carry(zCarNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weight <= W_INIT;
      aPre   <= '0;
      aPre3  <= '0;
      bPre   <= '0;
      bPre3  <= '0;
      zSum   <= '0;
      zCar   <= '0;
      pDigit <= '0;
      pValid <= 1'b0;
      pLast  <= 1'b0;
    end else if (ctl.clear) begin
      weight <= W_INIT;
      aPre   <= '0;
      aPre3  <= '0;
      bPre   <= '0;
      bPre3  <= '0;
      zSum   <= '0;
      zCar   <= '0;
      pDigit <= '0;
      pValid <= 1'b0;
      pLast  <= 1'b0;
    end else if (ctl.step) begin
      weight <= weight >>> 2;
      aPre   <= aNew;
      aPre3  <= aNew3;
      bPre   <= bNew;
      bPre3  <= bNew3;
      zSum   <= zSumNext;
      zCar   <= zCarNext;
      pDigit <= pSel;
      pValid <= 1'b1;
      pLast  <= ctl.last;
    end else begin
      pValid <= 1'b0;
      pLast  <= 1'b0;
    end
  end

  logic signed [RW-1:0] zTotal;
  assign zTotal = zSum + zCar;

  // R3: an emitted digit is never the unused code 3'b100
  assert_digit_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    pValid |-> (pDigit != 3'b100));

  // R4: every step yields a valid digit one cycle later
  assert_step_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> pValid);

  // R7: no step, no digit
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.step |=> !pValid);

  // R5: the final-digit mark only rides on a valid digit
  assert_last_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    pLast |-> pValid);

  // R6: after each step the residual lies in [-1/2, 1/2)
  assert_residual_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    pValid |-> (zTotal >= -HALF && zTotal < HALF));

endmodule

// File: rtl/msdf_mul_r4.sv
module msdf_mul_r4
  import msdf_mul_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       digValid,
  input  logic [2:0] aDigit,
  input  logic [2:0] bDigit,
  output logic [2:0] pDigit,
  output logic       pValid,
  output logic       pLast
);

  stepCtl_t ctl;

  msdf_mul_ctrl #(.NDIG(NDIG)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .digValid (digValid),
    .ctl      (ctl)
  );

  msdf_mul_datapath #(.NDIG(NDIG)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .aDigit (aDigit),
    .bDigit (bDigit),
    .pDigit (pDigit),
    .pValid (pValid),
    .pLast  (pLast)
  );

endmodule

// File: tb/msdf_mul_r4_test.sv
module msdf_mul_r4_test;

  localparam int CLK_PERIOD = 10;
  localparam int NDIG       = 4;
  localparam int NVEC       = 8;
  localparam int VW         = 3 * NDIG;

  // Digit i of an operand sits at bits [3*(i-1) +: 3]; the table is written {d4,d3,d2,d1}
  localparam logic [VW-1:0] A_TAB [NVEC] = '{
    12'b011_011_011_011,
    12'b011_011_011_011,
    12'b101_101_101_101,
    12'b000_000_000_000,
    12'b111_001_101_010,
    12'b011_101_011_101,
    12'b001_000_000_000,
    12'b000_000_000_001
  };
  localparam logic [VW-1:0] B_TAB [NVEC] = '{
    12'b011_011_011_011,
    12'b101_101_101_101,
    12'b101_101_101_101,
    12'b011_011_011_011,
    12'b010_110_011_111,
    12'b101_011_101_011,
    12'b111_000_000_000,
    12'b000_000_000_001
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       digValid = 1'b0;
  logic [2:0] aDigit = 3'b000;
  logic [2:0] bDigit = 3'b000;
  logic [2:0] pDigit;
  logic       pValid;
  logic       pLast;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;
  logic [2:0] pGot [NDIG+1];

  msdf_mul_r4 #(.NDIG(NDIG)) uut (
    .clk(clk), .rstN(rstN), .start(start), .digValid(digValid),
    .aDigit(aDigit), .bDigit(bDigit),
    .pDigit(pDigit), .pValid(pValid), .pLast(pLast)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint dval(input logic [2:0] d);
    return longint'($signed(d));
  endfunction

  function automatic longint pow4(input int e);
    longint v = 1;
    for (int i = 0; i < e; i++) v = v * 4;
    return v;
  endfunction

  // Operand value in units of 4^-NDIG
  function automatic longint prefixVal(input logic [VW-1:0] v);
    longint s = 0;
    for (int i = 1; i <= NDIG; i++) s += dval(v[3*(i-1) +: 3]) * pow4(NDIG - i);
    return s;
  endfunction

  // Product stream value in units of 4^-NDIG
  function automatic longint streamVal();
    longint s = 0;
    for (int i = 1; i <= NDIG + 1; i++) s += dval(pGot[i-1]) * pow4(NDIG - (i - 1));
    return s;
  endfunction

  task automatic runOp(input logic [VW-1:0] aV, input logic [VW-1:0] bV, input int gapAt);
    @(negedge clk);
    start = 1'b1; digValid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(pValid == 1'b0, "R9 pValid after start", longint'(pValid), 0);
    digValid = 1'b1; aDigit = aV[2:0]; bDigit = bV[2:0];
    for (int k = 1; k <= NDIG; k++) begin
      @(negedge clk);
      check(pValid == 1'b1, "R4 digit due one cycle after accept", longint'(pValid), 1);
      check(pLast == 1'b0, "R5 pLast before final digit", longint'(pLast), 0);
      check(pDigit != 3'b100, "R3 output digit code", dval(pDigit), -3);
      pGot[k-1] = pDigit;
      if (k == gapAt) begin
        digValid = 1'b0; aDigit = 3'b011; bDigit = 3'b101;
        for (int g = 0; g < 2; g++) begin
          @(negedge clk);
          check(pValid == 1'b0, "R7 no digit while stalled", longint'(pValid), 0);
        end
      end
      if (k < NDIG) begin
        digValid = 1'b1; aDigit = aV[3*k +: 3]; bDigit = bV[3*k +: 3];
      end else begin
        // junk during the trailing step must be ignored (R5)
        digValid = 1'b1; aDigit = 3'b011; bDigit = 3'b101;
      end
    end
    @(negedge clk);
    check(pValid == 1'b1, "R5 trailing digit valid", longint'(pValid), 1);
    check(pLast == 1'b1, "R5 trailing digit marked last", longint'(pLast), 1);
    pGot[NDIG] = pDigit;
    digValid = 1'b0;
    @(negedge clk);
    check(pValid == 1'b0, "R5 pValid low after last digit", longint'(pValid), 0);
  endtask

  task automatic checkProduct(input logic [VW-1:0] aV, input logic [VW-1:0] bV, input string req);
    longint exact, got, err;
    exact = prefixVal(aV) * prefixVal(bV);        // units of 4^-2NDIG
    got   = streamVal() * pow4(NDIG);             // same units
    err   = exact - got;
    if (err < 0) err = -err;
    check(2 * err <= pow4(NDIG), req, got, exact);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(pValid == 1'b0, "R1 pValid in reset", longint'(pValid), 0);
    check(pLast == 1'b0, "R1 pLast in reset", longint'(pLast), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(pValid == 1'b0, "R1 pValid after reset", longint'(pValid), 0);

    // R8: digits offered with no operation active
    digValid = 1'b1; aDigit = 3'b011; bDigit = 3'b011;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(pValid == 1'b0, "R8 idle digits ignored", longint'(pValid), 0);
    end
    digValid = 1'b0;

    // Vector table: R6 accuracy, stalls on odd rows (R7)
    for (int v = 0; v < NVEC; v++) begin
      runOp(A_TAB[v], B_TAB[v], (v % 2 == 1) ? 2 : 0);
      checkProduct(A_TAB[v], B_TAB[v], "R6 product within half ulp");
    end

    // R9 and R2: abandon a partial operation, then restart
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; digValid = 1'b1; aDigit = 3'b011; bDigit = 3'b110;
    @(negedge clk);
    aDigit = 3'b101; bDigit = 3'b011;
    @(negedge clk);
    digValid = 1'b0;
    runOp(A_TAB[7], B_TAB[7], 0);
    checkProduct(A_TAB[7], B_TAB[7], "R2 product after abandoned operation");
    // 1/4 * 1/4 = 1/16 is representable: digits 0,0,1,0,0 (R6)
    for (int i = 0; i <= NDIG; i++) begin
      check(dval(pGot[i]) == ((i == 2) ? 1 : 0), "R6 exact digit of representable product",
            dval(pGot[i]), (i == 2) ? 1 : 0);
    end

    // R2 again after a full mixed-sign operation
    runOp(A_TAB[4], B_TAB[4], 3);
    checkProduct(A_TAB[4], B_TAB[4], "R2 R7 product with late stall");

    // R1: reset in the middle of an operation
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; digValid = 1'b1; aDigit = 3'b010; bDigit = 3'b010;
    @(negedge clk);
    rstN = 1'b0; digValid = 1'b0;
    @(negedge clk);
    check(pValid == 1'b0, "R1 reset mid operation", longint'(pValid), 0);
    rstN = 1'b1;
    digValid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(pValid == 1'b0, "R1 no digit until start after reset", longint'(pValid), 0);
    digValid = 1'b0;

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule